// File: doc/BRIEF.md
# Exception Entry Capture Unit

This unit records the machine state at the moment a 32-bit core with branch delay slots takes an exception. A single-cycle request carries the exception code, the address of the faulting instruction, whether that instruction sat in a delay slot, whether the branch before it was taken, the coprocessor number, whether the fault came from the fetch side, the address being fetched at that moment, and a faulting data address. On the clock edge that samples the request, the unit updates the return address (EPC), the cause word, the branch-target register (TAR), the bad-address register and the status mode stack. One cycle later it raises a one-cycle vector request.

A small control FSM sequences the vector request. It has two states. `ST_IDLE` waits for a request. `ST_ENTRY` drives the vector request. The transition `T_RAISE` (IDLE→ENTRY) fires on a request. In ENTRY, `T_AGAIN` (ENTRY→ENTRY) fires on a back-to-back request, and `T_DONE` (ENTRY→IDLE) fires when no request is present. The unit also answers combinational register reads and accepts software writes for the status, cause and two breakpoint registers.

Exception codes that the unit itself interprets are: 4 for a load or fetch address error, 5 for a store address error, 6 for an instruction bus error, and 7 for a data bus error. Any other code is only recorded.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, EPC, TAR, BadVaddr, Status, Cause, the execute breakpoint and the data breakpoint all read 0, and `vec_req` is low.
- R2: An exception that is not in a delay slot stores `exc_pc` in EPC. It writes Cause with the code in bits 6:2, the coprocessor number in bits 29:28, bit 31 (in-slot) clear and bit 30 (taken) clear. TAR keeps its value.
- R3: A non-fetch exception with `exc_in_slot`=1 stores `exc_pc`−4 in EPC, modulo 2^32. It sets Cause bit 31, sets Cause bit 30 equal to `exc_taken`, and loads TAR with `exc_fetch_pc`.
- R4: A fetch-side exception (`exc_fetch`=1) ignores the slot and taken inputs. EPC gets `exc_pc`, Cause bits 31 and 30 are cleared, and TAR is unchanged. With code 4, BadVaddr also gets `exc_pc`.
- R5: Bus-error codes 6 and 7 record EPC and Cause but leave BadVaddr unchanged.
- R6: A non-fetch exception with code 4 or 5 loads BadVaddr with `exc_bad_addr`. Any other non-fetch code leaves BadVaddr unchanged.
- R7: On every exception, Status bits 5:0 become {old bits 3:0, 2'b00}, which enters kernel mode with interrupts off. Status bits 31:6 are unchanged.
- R8: A software write to Cause (select 13) changes only bits 9:8. Cause bits 15:10 always reflect `irq_hw`. The software bits 9:8 survive an exception.
- R9: `vec_req` is high in the cycle after each sampled request and low in the cycle after a cycle with no request.
- R10: A read in the same cycle as a request returns the value from before the update. If a request and a software write to Status arrive together, the exception update wins and the write is dropped.
- R11: The register selects are 3 (execute breakpoint), 5 (data breakpoint), 6 (TAR), 8 (BadVaddr), 12 (Status), 13 (Cause) and 14 (EPC). Any other select reads 0. Writes to selects 6, 8 and 14 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | One-cycle exception request |
| exc_code | input | 5 | Exception code |
| exc_pc | input | 32 | Address of the faulting instruction, or the fetch address for fetch faults |
| exc_in_slot | input | 1 | Faulting instruction is in a delay slot |
| exc_taken | input | 1 | Branch owning the delay slot was taken |
| exc_copn | input | 2 | Coprocessor number |
| exc_fetch | input | 1 | Fault arose on instruction fetch |
| exc_fetch_pc | input | 32 | Address being fetched when the exception is raised |
| exc_bad_addr | input | 32 | Faulting data address |
| irq_hw | input | 6 | Hardware interrupt pending lines |
| wr_en | input | 1 | Software register write strobe |
| wr_sel | input | 5 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 5 | Read register select |
| rd_data | output | 32 | Read data (combinational) |
| vec_req | output | 1 | Exception vector request |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, a 4-byte instruction step and a 6-bit mode stack. With these values the Cause field positions match the numbers given in the requirements. The same values make the EPC wrap from address 0 to 0xFFFFFFFC reachable. They also let three successive exceptions walk a non-zero mode stack fully to zero.

// File: rtl/exc_unit_pkg.sv
package exc_unit_pkg;
    localparam int unsigned CODE_W = 5;
    localparam int unsigned SEL_W  = 5;

    localparam logic [CODE_W-1:0] EXC_ADDR_LD = 5'd4;
    localparam logic [CODE_W-1:0] EXC_ADDR_ST = 5'd5;
    localparam logic [CODE_W-1:0] EXC_BUS_I   = 5'd6;
    localparam logic [CODE_W-1:0] EXC_BUS_D   = 5'd7;

    localparam logic [SEL_W-1:0] SEL_BPX   = 5'd3;
    localparam logic [SEL_W-1:0] SEL_BPD   = 5'd5;
    localparam logic [SEL_W-1:0] SEL_TAR   = 5'd6;
    localparam logic [SEL_W-1:0] SEL_BADV  = 5'd8;
    localparam logic [SEL_W-1:0] SEL_SR    = 5'd12;
    localparam logic [SEL_W-1:0] SEL_CAUSE = 5'd13;
    localparam logic [SEL_W-1:0] SEL_EPC   = 5'd14;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ENTRY = 1'b1
    } entry_state_e;
endpackage

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
    import exc_unit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_valid,
    output logic capture,
    output logic vec_req
);
    entry_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (exc_valid) state_d = ST_ENTRY;          // T_RAISE
            ST_ENTRY: state_d = exc_valid ? ST_ENTRY : ST_IDLE;   // T_AGAIN / T_DONE
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        capture = exc_valid;
        vec_req = 1'b0;
        unique case (state_q)
            ST_IDLE:  vec_req = 1'b0;
            ST_ENTRY: vec_req = 1'b1;
            default:  vec_req = 1'b0;
        endcase
    end

    p_vec_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> vec_req);
    p_vec_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |=> !vec_req);
endmodule

// File: rtl/exc_addr_capture.sv
module exc_addr_capture
    import exc_unit_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] code,
    input  logic              fetch,
    input  logic              in_slot,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   fetch_pc,
    input  logic [XLEN-1:0]   bad_addr,
    output logic [XLEN-1:0]   epc,
    output logic [XLEN-1:0]   tar,
    output logic [XLEN-1:0]   badv
);
    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    logic slot_eff;
    logic badv_from_pc;
    logic badv_from_data;

    always_comb begin
        slot_eff       = in_slot & ~fetch;
        badv_from_pc   = fetch & (code == EXC_ADDR_LD);
        badv_from_data = ~fetch & ((code == EXC_ADDR_LD) | (code == EXC_ADDR_ST));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc  <= '0;
            tar  <= '0;
            badv <= '0;
        end else if (capture) begin
            epc <= slot_eff ? (pc - STEP) : pc;
            if (slot_eff)            tar  <= fetch_pc;
            if (badv_from_pc)        badv <= pc;
            else if (badv_from_data) badv <= bad_addr;
        end
    end

    p_epc_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        capture && in_slot && !fetch |=> epc == $past(pc) - STEP);
    p_tar_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        capture && in_slot && !fetch |=> tar == $past(fetch_pc));
    p_tar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture && !(in_slot && !fetch) |=> $stable(tar));
    p_fetch_epc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture && fetch |=> epc == $past(pc));
    p_bus_badv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture && (code == EXC_BUS_I || code == EXC_BUS_D) |=> $stable(badv));
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
    import exc_unit_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned CE_W  = 2,
    parameter int unsigned IRQ_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] code,
    input  logic              fetch,
    input  logic              in_slot,
    input  logic              taken,
    input  logic [CE_W-1:0]   copn,
    input  logic [IRQ_W-1:0]  irq_hw,
    input  logic              sw_we,
    input  logic [1:0]        sw_bits,
    output logic [XLEN-1:0]   cause
);
    localparam int unsigned ZPAD = XLEN - 2 - CE_W - IRQ_W - 2 - 1 - CODE_W - 2;

    logic [CODE_W-1:0] code_q;
    logic [CE_W-1:0]   ce_q;
    logic              bd_q, bt_q;
    logic [1:0]        sw_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            ce_q   <= '0;
            bd_q   <= 1'b0;
            bt_q   <= 1'b0;
            sw_q   <= '0;
        end else if (capture) begin
            code_q <= code;
            ce_q   <= copn;
            bd_q   <= in_slot & ~fetch;
            bt_q   <= in_slot & taken & ~fetch;
        end else if (sw_we) begin
            sw_q <= sw_bits;
        end
    end

    always_comb begin
        cause = {bd_q, bt_q, ce_q, {ZPAD{1'b0}}, irq_hw, sw_q, 1'b0, code_q, 2'b00};
    end

    p_write_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we && !capture |=> cause[XLEN-1:16] == $past(cause[XLEN-1:16]) &&
                             cause[7:0] == $past(cause[7:0]));
    p_fetch_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture && fetch |=> cause[XLEN-1:XLEN-2] == 2'b00);
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned MODE_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            sw_we,
    input  logic [XLEN-1:0] sw_data,
    output logic [XLEN-1:0] sr
);
    always_ff @(posedge clk) begin
        if (!rst_n)       sr <= '0;
        else if (capture) sr <= {sr[XLEN-1:MODE_W], sr[MODE_W-3:0], 2'b00};
        else if (sw_we)   sr <= sw_data;
    end

    p_kernel_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> sr[1:0] == 2'b00);
    p_mode_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> sr[MODE_W-1:2] == $past(sr[MODE_W-3:0]));
    p_upper_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> $stable(sr[XLEN-1:MODE_W]));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_unit_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned PC_STEP = 4,
    parameter int unsigned MODE_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              exc_in_slot,
    input  logic              exc_taken,
    input  logic [1:0]        exc_copn,
    input  logic              exc_fetch,
    input  logic [XLEN-1:0]   exc_fetch_pc,
    input  logic [XLEN-1:0]   exc_bad_addr,
    input  logic [5:0]        irq_hw,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [XLEN-1:0]   rd_data,
    output logic              vec_req
);
    logic            capture;
    logic [XLEN-1:0] epc, tar, badv, cause, sr;
    logic [XLEN-1:0] bpx_q, bpd_q;
    logic            we_sr, we_cause;

    exc_entry_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid),
        .capture(capture), .vec_req(vec_req)
    );

    exc_addr_capture #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_addr (
        .clk(clk), .rst_n(rst_n), .capture(capture), .code(exc_code),
        .fetch(exc_fetch), .in_slot(exc_in_slot), .pc(exc_pc),
        .fetch_pc(exc_fetch_pc), .bad_addr(exc_bad_addr),
        .epc(epc), .tar(tar), .badv(badv)
    );

    always_comb begin
        we_sr    = wr_en && (wr_sel == SEL_SR);
        we_cause = wr_en && (wr_sel == SEL_CAUSE);
    end

    exc_cause_reg #(.XLEN(XLEN), .CE_W(2), .IRQ_W(6)) u_cause (
        .clk(clk), .rst_n(rst_n), .capture(capture), .code(exc_code),
        .fetch(exc_fetch), .in_slot(exc_in_slot), .taken(exc_taken),
        .copn(exc_copn), .irq_hw(irq_hw), .sw_we(we_cause),
        .sw_bits(wr_data[9:8]), .cause(cause)
    );

    exc_status_reg #(.XLEN(XLEN), .MODE_W(MODE_W)) u_status (
        .clk(clk), .rst_n(rst_n), .capture(capture), .sw_we(we_sr),
        .sw_data(wr_data), .sr(sr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bpx_q <= '0;
            bpd_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_BPX) bpx_q <= wr_data;
            if (wr_sel == SEL_BPD) bpd_q <= wr_data;
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_BPX:   rd_data = bpx_q;
            SEL_BPD:   rd_data = bpd_q;
            SEL_TAR:   rd_data = tar;
            SEL_BADV:  rd_data = badv;
            SEL_SR:    rd_data = sr;
            SEL_CAUSE: rd_data = cause;
            SEL_EPC:   rd_data = epc;
            default:   rd_data = '0;
        endcase
    end

    p_sw_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !exc_valid && (wr_sel == SEL_EPC) |=> $stable(epc));
endmodule

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/1ps
module test_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic        exc_in_slot = 1'b0;
    logic        exc_taken = 1'b0;
    logic [1:0]  exc_copn = '0;
    logic        exc_fetch = 1'b0;
    logic [31:0] exc_fetch_pc = '0;
    logic [31:0] exc_bad_addr = '0;
    logic [5:0]  irq_hw = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        vec_req;

    int checks = 0;
    int errors = 0;
    logic [31:0] tar_exp = '0;
    logic [31:0] badv_exp = '0;
    logic [31:0] v;

    always #2.5 clk = ~clk;

    exc_entry_unit i_exc_entry_unit (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_in_slot(exc_in_slot), .exc_taken(exc_taken),
        .exc_copn(exc_copn), .exc_fetch(exc_fetch), .exc_fetch_pc(exc_fetch_pc),
        .exc_bad_addr(exc_bad_addr), .irq_hw(irq_hw), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .vec_req(vec_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #0.5;
        val = rd_data;
    endtask

    function automatic logic [31:0] cause_of(input logic bd, input logic bt,
                                             input logic [1:0] ce, input logic [7:0] ip,
                                             input logic [4:0] code);
        return {bd, bt, ce, 12'h000, ip, 1'b0, code, 2'b00};
    endfunction

    // Issue one exception at a negedge; return at the next negedge with vec_req checked.
    task automatic fire(input logic [4:0] code, input logic [31:0] pc, input logic slot,
                        input logic taken, input logic [1:0] copn, input logic fetch,
                        input logic [31:0] fpc, input logic [31:0] bad);
        @(negedge clk);
        exc_code = code; exc_pc = pc; exc_in_slot = slot; exc_taken = taken;
        exc_copn = copn; exc_fetch = fetch; exc_fetch_pc = fpc; exc_bad_addr = bad;
        exc_valid = 1'b1;
        @(negedge clk);
        exc_valid = 1'b0;
        chk("R9 vec_req after request", {31'b0, vec_req}, 32'd1);
    endtask

    task automatic wr(input logic [4:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        rd(5'd14, v); chk("R1 EPC reset", v, 0);
        rd(5'd6,  v); chk("R1 TAR reset", v, 0);
        rd(5'd8,  v); chk("R1 BadVaddr reset", v, 0);
        rd(5'd12, v); chk("R1 Status reset", v, 0);
        rd(5'd13, v); chk("R1 Cause reset", v, 0);
        rd(5'd3,  v); chk("R1 exec bp reset", v, 0);
        rd(5'd5,  v); chk("R1 data bp reset", v, 0);
        chk("R1 vec_req reset", {31'b0, vec_req}, 0);
    endtask

    task automatic t_plain;
        fire(5'd8, 32'h8000_1000, 1'b0, 1'b1, 2'd2, 1'b0, 32'h8000_1008, 32'h0);
        rd(5'd14, v); chk("R2 EPC plain", v, 32'h8000_1000);
        rd(5'd13, v); chk("R2 Cause plain", v, cause_of(0, 0, 2'd2, 8'h00, 5'd8));
        rd(5'd6,  v); chk("R2 TAR held", v, tar_exp);
        @(negedge clk);
        chk("R9 vec_req single cycle", {31'b0, vec_req}, 0);
    endtask

    task automatic t_slot;
        fire(5'd10, 32'h8000_2004, 1'b1, 1'b1, 2'd0, 1'b0, 32'h8000_3000, 32'h0);
        tar_exp = 32'h8000_3000;
        rd(5'd14, v); chk("R3 EPC slot taken", v, 32'h8000_2000);
        rd(5'd13, v); chk("R3 Cause slot taken", v, cause_of(1, 1, 2'd0, 8'h00, 5'd10));
        rd(5'd6,  v); chk("R3 TAR slot taken", v, tar_exp);
        fire(5'd12, 32'h0000_0100, 1'b1, 1'b0, 2'd1, 1'b0, 32'h0000_0108, 32'h0);
        tar_exp = 32'h0000_0108;
        rd(5'd14, v); chk("R3 EPC slot not taken", v, 32'h0000_00FC);
        rd(5'd13, v); chk("R3 Cause slot not taken", v, cause_of(1, 0, 2'd1, 8'h00, 5'd12));
        rd(5'd6,  v); chk("R3 TAR slot not taken", v, tar_exp);
        fire(5'd9, 32'h0000_0000, 1'b1, 1'b1, 2'd0, 1'b0, 32'h0000_0040, 32'h0);
        tar_exp = 32'h0000_0040;
        rd(5'd14, v); chk("R3 EPC wrap", v, 32'hFFFF_FFFC);
    endtask

    task automatic t_fetch;
        fire(5'd4, 32'h8000_0003, 1'b1, 1'b1, 2'd3, 1'b1, 32'h1234_5678, 32'h5555_0000);
        badv_exp = 32'h8000_0003;
        rd(5'd14, v); chk("R4 EPC fetch addr err", v, 32'h8000_0003);
        rd(5'd8,  v); chk("R4 BadVaddr fetch addr err", v, badv_exp);
        rd(5'd13, v); chk("R4 Cause flags cleared", v, cause_of(0, 0, 2'd3, 8'h00, 5'd4));
        rd(5'd6,  v); chk("R4 TAR unchanged", v, tar_exp);
        fire(5'd6, 32'h1FC0_0000, 1'b0, 1'b0, 2'd0, 1'b1, 32'h1FC0_0004, 32'h0000_DEAD);
        rd(5'd14, v); chk("R5 EPC fetch bus err", v, 32'h1FC0_0000);
        rd(5'd8,  v); chk("R5 BadVaddr kept on bus err", v, badv_exp);
        fire(5'd7, 32'h0000_2000, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0000_2004, 32'h0000_BEEF);
        rd(5'd8,  v); chk("R5 BadVaddr kept on data bus err", v, badv_exp);
    endtask

    task automatic t_data_addr;
        fire(5'd5, 32'h0000_3000, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0000_3004, 32'h0000_0101);
        badv_exp = 32'h0000_0101;
        rd(5'd8, v); chk("R6 BadVaddr store addr err", v, badv_exp);
        fire(5'd4, 32'h0000_3010, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0000_3014, 32'h0000_0203);
        badv_exp = 32'h0000_0203;
        rd(5'd8, v); chk("R6 BadVaddr load addr err", v, badv_exp);
        fire(5'd8, 32'h0000_3020, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0000_3024, 32'h0000_0777);
        rd(5'd8, v); chk("R6 BadVaddr kept on other code", v, badv_exp);
    endtask

    task automatic t_mode;
        wr(5'd12, 32'hABCD_0013);
        rd(5'd12, v); chk("R11 Status write", v, 32'hABCD_0013);
        fire(5'd8, 32'h10, 1'b0, 1'b0, 2'd0, 1'b0, 32'h14, 32'h0);
        rd(5'd12, v); chk("R7 mode push 1", v, 32'hABCD_000C);
        fire(5'd8, 32'h10, 1'b0, 1'b0, 2'd0, 1'b0, 32'h14, 32'h0);
        rd(5'd12, v); chk("R7 mode push 2", v, 32'hABCD_0030);
        fire(5'd8, 32'h10, 1'b0, 1'b0, 2'd0, 1'b0, 32'h14, 32'h0);
        rd(5'd12, v); chk("R7 mode push 3", v, 32'hABCD_0000);
    endtask

    task automatic t_cause_write;
        fire(5'd11, 32'h40, 1'b1, 1'b1, 2'd1, 1'b0, 32'h80, 32'h0);
        tar_exp = 32'h80;
        irq_hw = 6'b101001;
        wr(5'd13, 32'hFFFF_FFFF);
        rd(5'd13, v); chk("R8 Cause write mask", v, cause_of(1, 1, 2'd1, 8'hA7, 5'd11));
        fire(5'd9, 32'h50, 1'b0, 1'b0, 2'd0, 1'b0, 32'h54, 32'h0);
        rd(5'd13, v); chk("R8 sw bits survive exception", v, cause_of(0, 0, 2'd0, 8'hA7, 5'd9));
        irq_hw = 6'b000000;
        wr(5'd13, 32'h0000_0100);
        rd(5'd13, v); chk("R8 sw bit clear and irq follow", v, cause_of(0, 0, 2'd0, 8'h01, 5'd9));
    endtask

    task automatic t_same_cycle;
        wr(5'd12, 32'h0000_0005);
        @(negedge clk);
        exc_code = 5'd8; exc_pc = 32'h0000_7000; exc_in_slot = 1'b0; exc_taken = 1'b0;
        exc_copn = 2'd0; exc_fetch = 1'b0; exc_fetch_pc = 32'h0000_7004; exc_bad_addr = 0;
        exc_valid = 1'b1;
        wr_en = 1'b1; wr_sel = 5'd12; wr_data = 32'hFFFF_FFFF;
        rd(5'd14, v); chk("R10 read returns old EPC", v, 32'h0000_0050);
        @(negedge clk);
        exc_valid = 1'b0; wr_en = 1'b0;
        rd(5'd14, v); chk("R10 EPC after update", v, 32'h0000_7000);
        rd(5'd12, v); chk("R10 exception wins over Status write", v, 32'h0000_0014);
    endtask

    task automatic t_selects;
        wr(5'd14, 32'h1111_1111);
        rd(5'd14, v); chk("R11 EPC write ignored", v, 32'h0000_7000);
        wr(5'd6, 32'h2222_2222);
        rd(5'd6, v);  chk("R11 TAR write ignored", v, tar_exp);
        wr(5'd8, 32'h3333_3333);
        rd(5'd8, v);  chk("R11 BadVaddr write ignored", v, badv_exp);
        wr(5'd3, 32'hCAFE_0001);
        wr(5'd5, 32'hCAFE_0002);
        rd(5'd3, v);  chk("R11 exec bp", v, 32'hCAFE_0001);
        rd(5'd5, v);  chk("R11 data bp", v, 32'hCAFE_0002);
        rd(5'd9, v);  chk("R11 unmapped select", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_slot();
        t_fetch();
        t_data_addr();
        t_mode();
        t_cause_write();
        t_same_cycle();
        t_selects();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule